// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer Channel

This block is one programmable timer channel. It has a single counter core and one bidirectional pin, split into an input, an output and an output enable. The channel runs in one of three modes. In the first it drives a pulse-width-modulated waveform out of the pin. In the second it counts rising edges that arrive on the pin. In the third it measures the high time and the repetition time of an external signal on the pin. That last mode is fine enough to time single bits of a serial line, so firmware can work out an unknown baud rate.

The counter advances on ticks from one of three sources: the system clock itself, or the rising edges of either of two external clock inputs. Every external signal is first brought into the system clock domain by a two-flop synchroniser and then passed through an edge detector. For this reason an external clock must stay below half the system clock rate. Configuration comes in as plain level inputs (enable, mode, clock source, period, width). Captured values, a sticky overflow flag and a one-cycle interrupt go out.

Top module: `gp_timer`

## Requirements
- R1: While reset is asserted, `pin_out`, `pin_oe`, `irq`, `cap_period`, `cap_width` and `ovf_flag` are all zero.
- R2: With `cfg_mode`=0 (waveform output), `pin_oe` is 1. Each period lasts P ticks, and `pin_out` is high for the first W ticks of it and low for the rest. `irq` is high for exactly one system cycle per period, in the cycle where the period's first tick appears on `pin_out`.
- R3: With `cfg_en`=0, or with `cfg_mode`=3, the counter is cleared and `pin_out`, `pin_oe` and `irq` are low from the next cycle onward.
- R4: `cfg_clksel` picks the tick source: 0 or 3 selects the system clock, 1 selects rising edges of `ext_clk_a`, and 2 selects rising edges of `ext_clk_b`. An external clock must run slower than half the system clock.
- R5: With `cfg_mode`=1 (edge counting), `pin_oe` is 0 and `irq` pulses once for every P rising edges seen on `pin_in`.
- R6: With `cfg_mode`=2 (capture), each rising edge of `pin_in` loads `cap_period` with the number of ticks since the previous rising edge and restarts the count. `irq` pulses on every rising edge except the first one after the mode starts.
- R7: In capture mode, each falling edge of `pin_in` after the first rising edge loads `cap_width` with the number of ticks since that rising edge.
- R8: In capture mode the counter stops at its all-ones value. Reaching that value sets `ovf_flag`, which then stays set until `ovf_clr` is pulsed. If a new overflow and a clear happen in the same cycle, the overflow wins.
- R9: A width of 0 holds `pin_out` low for the whole period. A width of P or more holds it high for the whole period.
- R10: Changes to `cfg_period` and `cfg_width` take effect only at the next period boundary, so a period that has already started completes with its old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | 0 waveform, 1 edge count, 2 capture, 3 off |
| cfg_clksel | input | 2 | Tick source: 0/3 system, 1 ext A, 2 ext B |
| cfg_period | input | CNT_W | Period P in ticks (0 acts as 1); edge count P |
| cfg_width | input | CNT_W | High time W in ticks |
| ovf_clr | input | 1 | Clears the overflow flag |
| pin_in | input | 1 | Pin input level |
| ext_clk_a | input | 1 | External tick source A |
| ext_clk_b | input | 1 | External tick source B |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt pulse |
| cap_period | output | CNT_W | Last captured period |
| cap_width | output | CNT_W | Last captured high time |
| ovf_flag | output | 1 | Sticky capture overflow |

## Verification
The waveform mode is driven from a table of period and width pairs. The table includes widths of zero, equal to the period and above the period, and a period of one; the measured high time and irq spacing separate correct clamping from off-by-one compare errors. Tick sources are told apart by running an identical waveform setup from external clock A, from a silent clock B and from code 3, where the irq spacing is a multiple of the external clock period or of the system clock. Capture is tried with two different duty patterns, so that swapped or stale period and width registers show up, and edge counting is tried with a count that is not one, so that an irq on every edge is caught.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_PWM = 2'd0,
        MODE_EVT = 2'd1,
        MODE_CAP = 2'd2,
        MODE_OFF = 2'd3
    } gpt_mode_e;

    typedef enum logic [1:0] {
        CLK_SYS  = 2'd0,
        CLK_EXTA = 2'd1,
        CLK_EXTB = 2'd2,
        CLK_ALT  = 2'd3
    } gpt_clk_e;

endpackage

// File: rtl/gpt_sync_edge.sv
// Two-flop synchroniser plus edge detector for N asynchronous inputs.
module gpt_sync_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] last;
    } sy_t;

    sy_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] =  st_q.sync[i] & ~st_q.last[i];
        assign fall_o[i] = ~st_q.sync[i] &  st_q.last[i];
    end

endmodule

// File: rtl/gpt_tick_sel.sv
// Picks the counter tick source.
module gpt_tick_sel
    import gpt_pkg::*;
(
    input  gpt_clk_e sel_i,
    input  logic     exta_rise_i,
    input  logic     extb_rise_i,
    output logic     tick_o
);

    always_comb begin
        case (sel_i)
            CLK_EXTA: tick_o = exta_rise_i;
            CLK_EXTB: tick_o = extb_rise_i;
            default:  tick_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/gpt_core.sv
// Shared counter for waveform, edge counting and capture.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  gpt_mode_e        mode_i,
    input  logic             tick_i,
    input  logic             pin_rise_i,
    input  logic             pin_fall_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             ovf_clr_i,
    output logic             pin_out_o,
    output logic             pin_oe_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] cap_period_o,
    output logic [CNT_W-1:0] cap_width_o,
    output logic             ovf_o
);

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};
    localparam cnt_t CNT_ONE = cnt_t'(1);

    typedef struct packed {
        cnt_t      cnt;
        cnt_t      per_sh;
        cnt_t      wid_sh;
        cnt_t      cap_per;
        cnt_t      cap_wid;
        gpt_mode_e mode;
        logic      run;
        logic      armed;
        logic      out;
        logic      oe;
        logic      irq;
        logic      ovf;
    } core_t;

    core_t st_d, st_q;
    cnt_t  per_eff;
    cnt_t  elapsed;
    logic  restart;
    logic  wrap;
    logic  ovf_set;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        ovf_set  = 1'b0;
        per_eff  = (period_i == '0) ? CNT_ONE : period_i;
        elapsed  = (tick_i && st_q.cnt != CNT_MAX) ? st_q.cnt + CNT_ONE : st_q.cnt;
        restart  = !st_q.run || (st_q.mode != mode_i);
        wrap     = (st_q.cnt >= st_q.per_sh - CNT_ONE);

        if (!en_i || mode_i == MODE_OFF) begin
            st_d.cnt   = '0;
            st_d.run   = 1'b0;
            st_d.armed = 1'b0;
            st_d.out   = 1'b0;
            st_d.oe    = 1'b0;
        end else begin
            st_d.mode = mode_i;
            st_d.run  = 1'b1;
            case (mode_i)
                MODE_PWM: begin
                    st_d.oe = 1'b1;
                    if (restart) begin
                        st_d.cnt    = '0;
                        st_d.per_sh = per_eff;
                        st_d.wid_sh = width_i;
                    end else if (tick_i) begin
                        if (wrap) begin
                            st_d.cnt    = '0;
                            st_d.per_sh = per_eff;
                            st_d.wid_sh = width_i;
                            st_d.irq    = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_ONE;
                        end
                    end
                    st_d.out = (st_d.cnt < st_d.wid_sh);
                end
                MODE_EVT: begin
                    st_d.oe  = 1'b0;
                    st_d.out = 1'b0;
                    if (restart) begin
                        st_d.cnt    = '0;
                        st_d.per_sh = per_eff;
                    end else if (pin_rise_i) begin
                        if (wrap) begin
                            st_d.cnt    = '0;
                            st_d.per_sh = per_eff;
                            st_d.irq    = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_ONE;
                        end
                    end
                end
                default: begin
                    st_d.oe  = 1'b0;
                    st_d.out = 1'b0;
                    if (restart) begin
                        st_d.cnt   = '0;
                        st_d.armed = 1'b0;
                    end else if (pin_rise_i) begin
                        if (st_q.armed) begin
                            st_d.cap_per = elapsed;
                            st_d.irq     = 1'b1;
                        end
                        st_d.armed = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = elapsed;
                        if (pin_fall_i && st_q.armed) st_d.cap_wid = elapsed;
                        if (st_q.cnt != CNT_MAX && elapsed == CNT_MAX) ovf_set = 1'b1;
                    end
                end
            endcase
        end

        st_d.ovf = (st_q.ovf && !ovf_clr_i) || ovf_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.per_sh <= CNT_ONE;
            st_q.mode   <= MODE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out_o    = st_q.out;
    assign pin_oe_o     = st_q.oe;
    assign irq_o        = st_q.irq;
    assign cap_period_o = st_q.cap_per;
    assign cap_width_o  = st_q.cap_wid;
    assign ovf_o        = st_q.ovf;

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_clksel,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             ovf_clr,
    input  logic             pin_in,
    input  logic             ext_clk_a,
    input  logic             ext_clk_b,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq,
    output logic [CNT_W-1:0] cap_period,
    output logic [CNT_W-1:0] cap_width,
    output logic             ovf_flag
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] rises;
    logic [NSYNC-1:0] falls;
    logic             pin_rise;
    logic             pin_fall;
    logic             tick;

    gpt_sync_edge #(.N(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_clk_b, ext_clk_a, pin_in}),
        .rise_o  (rises),
        .fall_o  (falls)
    );

    assign pin_rise = rises[0];
    assign pin_fall = falls[0];

    gpt_tick_sel u_tick (
        .sel_i       (gpt_clk_e'(cfg_clksel)),
        .exta_rise_i (rises[1]),
        .extb_rise_i (rises[2]),
        .tick_o      (tick)
    );

    gpt_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cfg_en),
        .mode_i       (gpt_mode_e'(cfg_mode)),
        .tick_i       (tick),
        .pin_rise_i   (pin_rise),
        .pin_fall_i   (pin_fall),
        .period_i     (cfg_period),
        .width_i      (cfg_width),
        .ovf_clr_i    (ovf_clr),
        .pin_out_o    (pin_out),
        .pin_oe_o     (pin_oe),
        .irq_o        (irq),
        .cap_period_o (cap_period),
        .cap_width_o  (cap_width),
        .ovf_o        (ovf_flag)
    );

endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [1:0]       cfg_mode,
    input logic             ovf_clr,
    input logic             pin_rise,
    input logic             pin_fall,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             irq,
    input logic [CNT_W-1:0] cap_period,
    input logic [CNT_W-1:0] cap_width,
    input logic             ovf_flag
);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!pin_oe && !pin_out && !irq));

    a_r5_evt_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_mode == 2'd1) |=> !pin_oe);

    a_r5_evt_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(cfg_en && cfg_mode == 2'd1)) |-> $past(pin_rise));

    a_r6_cap_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(cfg_en && cfg_mode == 2'd2)) |-> $past(pin_rise));

    a_r6_period_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_period) |-> $past(pin_rise));

    a_r7_width_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_width) |-> $past(pin_fall));

    a_r8_ovf_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(cfg_en && cfg_mode == 2'd2));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .ovf_clr    (ovf_clr),
    .pin_rise   (pin_rise),
    .pin_fall   (pin_fall),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .cap_period (cap_period),
    .cap_width  (cap_width),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_gp_timer.sv
module tb_gp_timer;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = 2'd3;
    logic [1:0]    cfg_clksel = 2'd0;
    logic [CW-1:0] cfg_period = '0;
    logic [CW-1:0] cfg_width = '0;
    logic          ovf_clr = 1'b0;
    logic          pin_in = 1'b0;
    logic          ext_clk_a = 1'b0;
    logic          ext_clk_b = 1'b0;
    logic          pin_out, pin_oe, irq, ovf_flag;
    logic [CW-1:0] cap_period, cap_width;

    int n_run = 0;
    int n_fail = 0;
    int irq_seen = 0;
    int cyc = 0;
    int per, hi;

    gp_timer #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_clksel(cfg_clksel), .cfg_period(cfg_period), .cfg_width(cfg_width),
        .ovf_clr(ovf_clr), .pin_in(pin_in), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .cap_period(cap_period),
        .cap_width(cap_width), .ovf_flag(ovf_flag)
    );

    always #2 clk = ~clk;
    initial forever #12 ext_clk_a = ~ext_clk_a;

    always @(negedge clk) irq_seen += int'(irq);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    localparam int NV = 8;
    // {period, width, expected high ticks} for R2 and R9
    localparam int VEC [NV][3] = '{
        '{6, 2, 2}, '{6, 0, 0}, '{6, 6, 6}, '{6, 9, 6},
        '{1, 1, 1}, '{1, 0, 0}, '{9, 4, 4}, '{3, 1, 1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    endtask

    // measure one waveform period starting at an irq cycle
    task automatic measure(output int p, output int h);
        wait_irq();
        p = 0; h = 0;
        do begin
            h += int'(pin_out);
            @(negedge clk);
            p++;
        end while (!irq && p < 2000);
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] cs,
                         input int p, input int w);
        cfg_en = 1'b0;
        steps(2);
        cfg_mode = m; cfg_clksel = cs;
        cfg_period = CW'(p); cfg_width = CW'(w);
        cfg_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_pin(input int h, input int l);
        pin_in = 1'b1; steps(h);
        pin_in = 1'b0; steps(l);
    endtask

    initial begin
        steps(3);
        // R1: reset state
        chk(pin_out == 0 && pin_oe == 0 && irq == 0, "R1 outs", int'(pin_out | pin_oe | irq), 0);
        chk(cap_period == 0 && cap_width == 0 && ovf_flag == 0, "R1 caps",
            int'(cap_period) + int'(cap_width) + int'(ovf_flag), 0);
        rst_n = 1'b1;
        steps(2);

        // R2 / R9: table of period/width pairs on the system clock
        for (int v = 0; v < NV; v++) begin
            start(2'd0, 2'd0, VEC[v][0], VEC[v][1]);
            chk(pin_oe == 1, "R2 oe", int'(pin_oe), 1);
            measure(per, hi);
            measure(per, hi);
            chk(per == VEC[v][0], "R2 period", per, VEC[v][0]);
            chk(hi == VEC[v][2], "R9 high time", hi, VEC[v][2]);
        end

        // R10: change mid-period, old values finish the period
        start(2'd0, 2'd0, 10, 3);
        wait_irq();
        per = 0; hi = 0;
        do begin
            hi += int'(pin_out);
            if (per == 1) begin cfg_width = 8'd7; cfg_period = 8'd12; end
            @(negedge clk);
            per++;
        end while (!irq && per < 2000);
        chk(per == 10, "R10 old period", per, 10);
        chk(hi == 3, "R10 old width", hi, 3);
        measure(per, hi);
        chk(per == 12, "R10 new period", per, 12);
        chk(hi == 7, "R10 new width", hi, 7);

        // R4: tick sources
        start(2'd0, 2'd1, 5, 2);
        measure(per, hi);
        measure(per, hi);
        chk(per == 30, "R4 ext A period", per, 30);
        chk(hi == 12, "R4 ext A high", hi, 12);
        start(2'd0, 2'd2, 5, 2);
        irq_seen = 0;
        steps(100);
        chk(irq_seen == 0, "R4 ext B silent", irq_seen, 0);
        start(2'd0, 2'd3, 5, 2);
        measure(per, hi);
        measure(per, hi);
        chk(per == 5, "R4 code 3 system", per, 5);

        // R3: disable
        cfg_en = 1'b0;
        steps(2);
        chk(pin_out == 0 && pin_oe == 0 && irq == 0, "R3 disabled", int'(pin_out | pin_oe | irq), 0);
        start(2'd3, 2'd0, 5, 2);
        steps(8);
        chk(pin_oe == 0 && pin_out == 0, "R3 mode off", int'(pin_oe | pin_out), 0);

        // R5: edge counting, P=4, 12 edges
        start(2'd1, 2'd0, 4, 0);
        irq_seen = 0;
        for (int e = 0; e < 12; e++) pulse_pin(3, 3);
        steps(4);
        chk(irq_seen == 3, "R5 irq count", irq_seen, 3);
        chk(pin_oe == 0, "R5 no drive", int'(pin_oe), 0);

        // R6 / R7: capture, two duty patterns
        start(2'd2, 2'd0, 0, 0);
        steps(5);
        irq_seen = 0;
        for (int k = 0; k < 4; k++) pulse_pin(7, 13);
        chk(irq_seen == 3, "R6 irq count", irq_seen, 3);
        chk(cap_period == 20, "R6 period A", int'(cap_period), 20);
        chk(cap_width == 7, "R7 width A", int'(cap_width), 7);
        for (int k = 0; k < 3; k++) pulse_pin(3, 30);
        chk(cap_period == 33, "R6 period B", int'(cap_period), 33);
        chk(cap_width == 3, "R7 width B", int'(cap_width), 3);
        chk(ovf_flag == 0, "R8 no ovf yet", int'(ovf_flag), 0);

        // R8: overflow, sticky, clear
        steps(300);
        chk(ovf_flag == 1, "R8 ovf set", int'(ovf_flag), 1);
        steps(5);
        chk(ovf_flag == 1, "R8 ovf sticky", int'(ovf_flag), 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        steps(20);
        chk(ovf_flag == 0, "R8 ovf cleared", int'(ovf_flag), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule